// File: doc/BRIEF.md
# Per-Bank Precharge Timing Tracker

This block follows the row state of a single DRAM bank and tells a command scheduler, one cycle at a time, whether a PRECHARGE or an ACTIVATE is legal for that bank. Each clock it takes one encoded command for the bank. It also takes the timing configuration: the clock period and the analog minimums (row active time, precharge recovery for one bank and for all banks, read-to-precharge) in picoseconds, plus additive latency, CAS latency, burst length and the write-recovery code from the mode register. The analog times are turned into clock counts by rounding up.

Reads and writes that carry auto precharge are accepted as soon as the row is open. The internal precharge they trigger is held back until the minimum row-active time has elapsed, and until the read or write recovery has also run out. After a write with auto precharge, the bank becomes available again after the write latency plus half the burst plus the auto-precharge write recovery. That recovery is the write-recovery count plus the rounded-up precharge time. Any command issued while its flag is low sets a sticky violation output.

Top module: `bank_pre_tracker`

## Requirements
- R1: After synchronous reset the bank is closed, with `act_ok_o`=1, `pre_ok_o`=1 and `viol_o`=0.
- R2: `cmd_i` is decoded as follows: 0 idle, 1 ACTIVATE, 2 READ, 3 READ with auto precharge, 4 WRITE, 5 WRITE with auto precharge, 6 PRECHARGE, 7 PRECHARGE ALL. All cycle counts derived from picoseconds are ceil(t/tCK), with a minimum of 1.
- R3: A legal ACTIVATE sampled at edge k opens the bank. `act_ok_o` stays low while the bank is open, and `pre_ok_o` is low until edge k+ceil(tRAS/tCK).
- R4: A READ at edge k keeps `pre_ok_o` low until edge k+AL+BL/2+max(ceil(tRTP/tCK),2)−2. BL/2 is 2 when `cfg_bl8`=0 and 4 when `cfg_bl8`=1.
- R5: A WRITE at edge k keeps `pre_ok_o` low until edge k+(AL+CL−1)+BL/2+nWR, where nWR = `cfg_wr_code`+1.
- R6: A legal PRECHARGE of an open bank at edge k closes the bank, and `act_ok_o` rises at edge k+ceil(tRP/tCK). PRECHARGE ALL uses ceil(tRPA/tCK) instead.
- R7: READ with auto precharge is accepted before tRAS has elapsed. The internal precharge occurs at edge P, the later of the read's R4 point and the ACTIVATE's R3 point, and `act_ok_o` rises at P+ceil(tRP/tCK).
- R8: WRITE with auto precharge places P at the later of its R5 point and the R3 point. `act_ok_o` rises at P+ceil(tRP/tCK). When tRAS is not binding, this equals write latency + BL/2 + (nWR + ceil(tRP/tCK)) after the command.
- R9: While an auto precharge is pending, both `pre_ok_o` and `act_ok_o` are low.
- R10: An ACTIVATE while `act_ok_o`=0, or a PRECHARGE / PRECHARGE ALL while `pre_ok_o`=0, sets `viol_o`. The flag stays set until reset, and the command has no other effect.
- R11: PRECHARGE or PRECHARGE ALL to a closed bank is legal and changes no timing.
- R12: READ or WRITE (with or without auto precharge) to a bank that is not open is ignored.
- R13: Several reads and writes to an open row keep the latest of their precharge points; a later command never shortens an earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Encoded command for this bank (R2) |
| cfg_tck_ps | input | 16 | Clock period, ps |
| cfg_tras_ps | input | 16 | Minimum row active time, ps |
| cfg_trp_ps | input | 16 | Single-bank precharge recovery, ps |
| cfg_trpa_ps | input | 16 | All-bank precharge recovery, ps |
| cfg_trtp_ps | input | 16 | Read-to-precharge minimum, ps |
| cfg_al | input | 3 | Additive latency, cycles |
| cfg_cl | input | 3 | CAS latency, cycles |
| cfg_bl8 | input | 1 | 1: burst of 8, 0: burst of 4 |
| cfg_wr_code | input | 3 | Write-recovery mode field; nWR = code+1 |
| act_ok_o | output | 1 | ACTIVATE legal at the next edge |
| pre_ok_o | output | 1 | PRECHARGE legal at the next edge |
| viol_o | output | 1 | Sticky illegal-command flag |

## Verification
The hardest situation to reach is an auto precharge whose internal launch is decided by the row-active lockout rather than by the read or write recovery. A second hard case is that launch landing on the same edge as another command. Directed sequences issue a read with auto precharge on the cycle right after ACTIVATE, with a long tRAS. They also issue a write with auto precharge well after tRAS, where the recovery term alone sets the reopen time (the 8-clock example with nWR=4, tRP=15 ns, tCK=3.75 ns). Random phases then redraw the clock period, latencies and burst length for every run, so that each of the two terms dominates in turn. A timestamp model checks both flags and the violation bit on every cycle.

// File: rtl/bank_tmg_pkg.sv
package bank_tmg_pkg;

    localparam int PS_W    = 16;
    localparam int CYC_W   = 8;
    localparam int LAT_W   = 3;
    localparam int CYC_MAX = (1 << CYC_W) - 1;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_RDA  = 3'd3,
        CMD_WR   = 3'd4,
        CMD_WRA  = 3'd5,
        CMD_PRE  = 3'd6,
        CMD_PREA = 3'd7
    } bank_cmd_e;

    typedef enum logic [1:0] {
        BK_CLOSED = 2'd0,
        BK_OPEN   = 2'd1,
        BK_APWAIT = 2'd2
    } bank_state_e;

    typedef struct packed {
        logic [CYC_W-1:0] ras;
        logic [CYC_W-1:0] rp;
        logic [CYC_W-1:0] rpa;
        logic [CYC_W-1:0] rd2pre;
        logic [CYC_W-1:0] wr2pre;
    } tmg_cyc_t;

    function automatic logic [CYC_W-1:0] sat_cyc(input int unsigned v);
        if (v == 0)       return CYC_W'(1);
        if (v > CYC_MAX)  return CYC_W'(CYC_MAX);
        return CYC_W'(v);
    endfunction

    function automatic int unsigned ps_to_cyc(input logic [PS_W-1:0] t_ps,
                                              input logic [PS_W-1:0] tck_ps);
        int unsigned a;
        int unsigned b;
        a = 32'(t_ps);
        b = (tck_ps == '0) ? 32'd1 : 32'(tck_ps);
        return (a + b - 32'd1) / b;
    endfunction

endpackage

// File: rtl/bank_tmg_cfg.sv
module bank_tmg_cfg
    import bank_tmg_pkg::*;
(
    input  logic [PS_W-1:0]  tck_ps,
    input  logic [PS_W-1:0]  tras_ps,
    input  logic [PS_W-1:0]  trp_ps,
    input  logic [PS_W-1:0]  trpa_ps,
    input  logic [PS_W-1:0]  trtp_ps,
    input  logic [LAT_W-1:0] al,
    input  logic [LAT_W-1:0] cl,
    input  logic             bl8,
    input  logic [LAT_W-1:0] wr_code,
    output tmg_cyc_t         cyc_o
);
    int unsigned half_burst;
    int unsigned rtp_cyc;
    int unsigned nwr;
    int unsigned rd_raw;
    int unsigned wr_raw;

    always_comb begin
        half_burst = bl8 ? 32'd4 : 32'd2;
        rtp_cyc    = ps_to_cyc(trtp_ps, tck_ps);
        if (rtp_cyc < 32'd2) rtp_cyc = 32'd2;
        nwr        = 32'(wr_code) + 32'd1;
        // read: AL + BL/2, stretched only when tRTP spans more than two clocks
        rd_raw     = 32'(al) + half_burst + rtp_cyc - 32'd2;
        // write: write latency (AL+CL-1) + BL/2 + write recovery
        wr_raw     = 32'(al) + 32'(cl) + half_burst + nwr - 32'd1;

        cyc_o.ras    = sat_cyc(ps_to_cyc(tras_ps, tck_ps));
        cyc_o.rp     = sat_cyc(ps_to_cyc(trp_ps,  tck_ps));
        cyc_o.rpa    = sat_cyc(ps_to_cyc(trpa_ps, tck_ps));
        cyc_o.rd2pre = sat_cyc(rd_raw);
        cyc_o.wr2pre = sat_cyc(wr_raw);
    end

endmodule

// File: rtl/bank_tmg_dncnt.sv
module bank_tmg_dncnt #(
    parameter int W           = 8,
    parameter bit KEEP_LATEST = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_cyc,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] dec;
    logic [W-1:0] cand;
    logic [W-1:0] nxt;

    // a load of N cycles stores N-1 so the zero flag shows on the Nth edge
    assign dec  = (cnt_q == '0)    ? '0 : cnt_q - W'(1);
    assign cand = (load_cyc == '0) ? '0 : load_cyc - W'(1);

    generate
        if (KEEP_LATEST) begin : g_latest
            always_comb nxt = load ? ((cand > dec) ? cand : dec) : dec;
        end else begin : g_plain
            always_comb nxt = load ? cand : dec;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= nxt;
    end

    assign zero_o = (cnt_q == '0);

    AST_CNT_STAYS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!load && zero_o) |=> zero_o); // R3
    AST_CNT_LOAD_ARMS: assert property (@(posedge clk) disable iff (rst)
        (load && load_cyc > W'(1)) |=> !zero_o); // R13

endmodule

// File: rtl/bank_pre_tracker.sv
module bank_pre_tracker
    import bank_tmg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       cmd_i,
    input  logic [PS_W-1:0]  cfg_tck_ps,
    input  logic [PS_W-1:0]  cfg_tras_ps,
    input  logic [PS_W-1:0]  cfg_trp_ps,
    input  logic [PS_W-1:0]  cfg_trpa_ps,
    input  logic [PS_W-1:0]  cfg_trtp_ps,
    input  logic [LAT_W-1:0] cfg_al,
    input  logic [LAT_W-1:0] cfg_cl,
    input  logic             cfg_bl8,
    input  logic [LAT_W-1:0] cfg_wr_code,
    output logic             act_ok_o,
    output logic             pre_ok_o,
    output logic             viol_o
);
    bank_cmd_e   cmd;
    bank_state_e state_q, state_d;
    tmg_cyc_t    cyc;

    logic is_act, is_pre, is_rw, is_wr, is_ap;
    logic act_go, pre_go, rw_go, ap_fire, bad_cmd;
    logic ras_zero, rec_zero, rp_zero;
    logic rp_load;
    logic [CYC_W-1:0] rec_val, rp_val;
    logic viol_q;

    bank_tmg_cfg u_cfg (
        .tck_ps  (cfg_tck_ps),
        .tras_ps (cfg_tras_ps),
        .trp_ps  (cfg_trp_ps),
        .trpa_ps (cfg_trpa_ps),
        .trtp_ps (cfg_trtp_ps),
        .al      (cfg_al),
        .cl      (cfg_cl),
        .bl8     (cfg_bl8),
        .wr_code (cfg_wr_code),
        .cyc_o   (cyc)
    );

    assign cmd    = bank_cmd_e'(cmd_i);
    assign is_act = (cmd == CMD_ACT);
    assign is_pre = (cmd == CMD_PRE) || (cmd == CMD_PREA);
    assign is_wr  = (cmd == CMD_WR) || (cmd == CMD_WRA);
    assign is_rw  = is_wr || (cmd == CMD_RD) || (cmd == CMD_RDA);
    assign is_ap  = (cmd == CMD_RDA) || (cmd == CMD_WRA);

    assign act_ok_o = (state_q == BK_CLOSED) && rp_zero;
    assign pre_ok_o = (state_q == BK_CLOSED) ||
                      ((state_q == BK_OPEN) && ras_zero && rec_zero);

    // internal precharge waits for both the row-active lockout and recovery
    assign ap_fire = (state_q == BK_APWAIT) && ras_zero && rec_zero;
    assign act_go  = is_act && act_ok_o;
    assign pre_go  = is_pre && pre_ok_o && (state_q == BK_OPEN);
    assign rw_go   = is_rw && (state_q == BK_OPEN);
    assign bad_cmd = (is_act && !act_ok_o) || (is_pre && !pre_ok_o);

    assign rec_val = is_wr ? cyc.wr2pre : cyc.rd2pre;
    assign rp_load = pre_go || ap_fire;
    assign rp_val  = (pre_go && cmd == CMD_PREA) ? cyc.rpa : cyc.rp;

    bank_tmg_dncnt #(.W(CYC_W), .KEEP_LATEST(1'b0)) u_ras (
        .clk (clk), .rst (rst), .load (act_go),
        .load_cyc (cyc.ras), .zero_o (ras_zero)
    );

    bank_tmg_dncnt #(.W(CYC_W), .KEEP_LATEST(1'b1)) u_rec (
        .clk (clk), .rst (rst), .load (rw_go),
        .load_cyc (rec_val), .zero_o (rec_zero)
    );

    bank_tmg_dncnt #(.W(CYC_W), .KEEP_LATEST(1'b0)) u_rp (
        .clk (clk), .rst (rst), .load (rp_load),
        .load_cyc (rp_val), .zero_o (rp_zero)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BK_CLOSED: if (act_go) state_d = BK_OPEN;
            BK_OPEN: begin
                if (pre_go)                state_d = BK_CLOSED;
                else if (rw_go && is_ap)   state_d = BK_APWAIT;
            end
            BK_APWAIT: if (ap_fire) state_d = BK_CLOSED;
            default:   state_d = BK_CLOSED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BK_CLOSED;
            viol_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            viol_q  <= viol_q | bad_cmd;
        end
    end

    assign viol_o = viol_q;

    AST_ACT_BLOCKS_ACT: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == CMD_ACT && act_ok_o) |=> !act_ok_o); // R3
    AST_BAD_SETS_VIOL: assert property (@(posedge clk) disable iff (rst)
        ((cmd_i == CMD_ACT && !act_ok_o) ||
         ((cmd_i == CMD_PRE || cmd_i == CMD_PREA) && !pre_ok_o)) |=> viol_o); // R10
    AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (rst)
        viol_o |=> viol_o); // R10
    AST_AP_HELD_BY_RAS: assert property (@(posedge clk) disable iff (rst)
        (state_q == BK_APWAIT && !ras_zero) |=> !act_ok_o); // R7
    AST_AP_BLOCKS_PRE: assert property (@(posedge clk) disable iff (rst)
        ((cmd_i == CMD_RDA || cmd_i == CMD_WRA) && state_q == BK_OPEN) |=> !pre_ok_o); // R9
    AST_PRE_RECOVERY: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == CMD_PRE && pre_ok_o && state_q == BK_OPEN && cyc.rp > CYC_W'(1))
        |=> !act_ok_o); // R6

endmodule

// File: tb/sim_bank_pre_tracker.sv
`timescale 1ns/1ps
module sim_bank_pre_tracker;
    import bank_tmg_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst = 1'b1;
    logic [2:0]       cmd_i = 3'd0;
    logic [PS_W-1:0]  cfg_tck_ps, cfg_tras_ps, cfg_trp_ps, cfg_trpa_ps, cfg_trtp_ps;
    logic [LAT_W-1:0] cfg_al, cfg_cl, cfg_wr_code;
    logic             cfg_bl8;
    logic             act_ok_o, pre_ok_o, viol_o;

    bank_pre_tracker u0 (
        .clk (clk), .rst (rst), .cmd_i (cmd_i),
        .cfg_tck_ps (cfg_tck_ps), .cfg_tras_ps (cfg_tras_ps),
        .cfg_trp_ps (cfg_trp_ps), .cfg_trpa_ps (cfg_trpa_ps),
        .cfg_trtp_ps (cfg_trtp_ps), .cfg_al (cfg_al), .cfg_cl (cfg_cl),
        .cfg_bl8 (cfg_bl8), .cfg_wr_code (cfg_wr_code),
        .act_ok_o (act_ok_o), .pre_ok_o (pre_ok_o), .viol_o (viol_o)
    );

    int ncyc = 0;
    always @(posedge clk) begin
        if (rst) ncyc <= 0;
        else     ncyc <= ncyc + 1;
    end

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference model: 0 closed, 1 open, 2 auto precharge pending
    int mst, m_ep, m_ar;
    bit m_viol;
    int c_tck, c_tras, c_trp, c_trpa, c_trtp, c_al, c_cl, c_bl8, c_wr;

    function automatic int cyc_of(int t);
        int c;
        c = (t + c_tck - 1) / c_tck;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int half_bl();
        return c_bl8 ? 4 : 2;
    endfunction
    function automatic int rd_to_pre();
        int r;
        r = cyc_of(c_trtp);
        if (r < 2) r = 2;
        return c_al + half_bl() + r - 2;
    endfunction
    function automatic int wr_to_pre();
        return (c_al + c_cl - 1) + half_bl() + (c_wr + 1);
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, ncyc);
        end
    endtask

    task automatic set_cfg(int tck, int tras, int trp, int trpa, int trtp,
                           int al, int cl, int bl8, int wr);
        c_tck = tck; c_tras = tras; c_trp = trp; c_trpa = trpa; c_trtp = trtp;
        c_al = al; c_cl = cl; c_bl8 = bl8; c_wr = wr;
        cfg_tck_ps = PS_W'(tck); cfg_tras_ps = PS_W'(tras); cfg_trp_ps = PS_W'(trp);
        cfg_trpa_ps = PS_W'(trpa); cfg_trtp_ps = PS_W'(trtp);
        cfg_al = LAT_W'(al); cfg_cl = LAT_W'(cl); cfg_bl8 = bl8[0]; cfg_wr_code = LAT_W'(wr);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cmd_i = 3'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mst = 0; m_ep = 0; m_ar = 0; m_viol = 0;
        // R1: reset state
        chk("R1", "act_ok", int'(act_ok_o), 1);
        chk("R1", "pre_ok", int'(pre_ok_o), 1);
        chk("R1", "viol",   int'(viol_o),   0);
    endtask

    function automatic bit exp_act(int n);
        return (mst == 0) && (n >= m_ar);
    endfunction
    function automatic bit exp_pre(int n);
        return (mst == 0) || (mst == 1 && n >= m_ep);
    endfunction

    task automatic model_update(logic [2:0] c, int n);
        bit la, lp;
        int t;
        la = exp_act(n);
        lp = exp_pre(n);
        if ((c == CMD_ACT && !la) || ((c == CMD_PRE || c == CMD_PREA) && !lp)) m_viol = 1;
        if (mst == 2) begin
            if (n >= m_ep) begin
                mst = 0;
                m_ar = n + cyc_of(c_trp);
            end
        end else begin
            case (c)
                CMD_ACT: if (la) begin mst = 1; m_ep = n + cyc_of(c_tras); end
                CMD_RD, CMD_RDA, CMD_WR, CMD_WRA: if (mst == 1) begin
                    t = n + ((c == CMD_WR || c == CMD_WRA) ? wr_to_pre() : rd_to_pre());
                    if (t > m_ep) m_ep = t;
                    if (c == CMD_RDA || c == CMD_WRA) mst = 2;
                end
                CMD_PRE, CMD_PREA: if (mst == 1 && lp) begin
                    mst = 0;
                    m_ar = n + ((c == CMD_PREA) ? cyc_of(c_trpa) : cyc_of(c_trp));
                end
                default: ;
            endcase
        end
    endtask

    task automatic step(logic [2:0] c, string tag);
        int n;
        @(negedge clk);
        n = ncyc;
        chk(tag, "act_ok", int'(act_ok_o), int'(exp_act(n)));
        chk(tag, "pre_ok", int'(pre_ok_o), int'(exp_pre(n)));
        chk(tag, "viol",   int'(viol_o),   int'(m_viol));
        cmd_i = c;
        @(posedge clk);
        model_update(c, n);
    endtask

    task automatic idle(int k, string tag);
        for (int i = 0; i < k; i++) step(CMD_NOP, tag);
    endtask

    task automatic rand_cfg();
        int tcks[4];
        int tck, trp;
        tcks[0] = 2500; tcks[1] = 3000; tcks[2] = 3750; tcks[3] = 5000;
        tck = tcks[$urandom % 4];
        trp = 12500 + int'($urandom % 4) * 1250;
        set_cfg(tck, 40000 + int'($urandom % 6) * 1000, trp,
                trp + int'($urandom % 3) * tck,
                ($urandom % 2) ? 7500 : 10000,
                int'($urandom % 5), 3 + int'($urandom % 4),
                int'($urandom % 2), 1 + int'($urandom % 6));
    endtask

    task automatic rand_run(int steps, bit wild);
        logic [2:0] c;
        for (int i = 0; i < steps; i++) begin
            c = 3'($urandom % 8);
            if ($urandom % 3 == 0) c = CMD_NOP;
            if (!wild || ($urandom % 50 != 0)) begin
                if (c == CMD_ACT && !exp_act(ncyc)) c = CMD_NOP;
                if ((c == CMD_PRE || c == CMD_PREA) && !exp_pre(ncyc)) c = CMD_NOP;
            end
            step(c, "R2");
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // directed: tCK 3.75 ns, tRAS 12, tRP 4, tRPA 5, tRTP 2, AL 0, CL 4, BL4, nWR 4
        set_cfg(3750, 45000, 15000, 18750, 7500, 0, 4, 0, 3);
        do_reset();
        step(CMD_ACT, "R3");   idle(14, "R3");
        step(CMD_RD,  "R4");   idle(6,  "R4");
        step(CMD_WR,  "R5");
        step(CMD_RD,  "R13");  idle(12, "R5");
        step(CMD_PRE, "R6");   idle(6,  "R6");
        step(CMD_ACT, "R3");   idle(13, "R3");
        step(CMD_PREA,"R6");   idle(7,  "R6");
        step(CMD_PRE, "R11");  step(CMD_PREA, "R11");
        step(CMD_RD,  "R12");  step(CMD_WRA, "R12"); idle(3, "R12");
        step(CMD_ACT, "R7");   step(CMD_RDA, "R7");  idle(20, "R7");
        step(CMD_ACT, "R8");   idle(15, "R8");
        step(CMD_WRA, "R8");   idle(16, "R8");  // reopen 13 clocks after WRA (tDAL = 8)
        step(CMD_ACT, "R3");   step(CMD_ACT, "R10"); idle(3, "R10");
        do_reset();
        step(CMD_ACT, "R9");   step(CMD_RDA, "R9");
        step(CMD_PRE, "R9");   step(CMD_ACT, "R10"); idle(20, "R10");
        // read recovery stretched by tRTP (tCK 2.5 ns, tRTP 10 ns -> 4 clocks), BL8
        set_cfg(2500, 45000, 12500, 15000, 10000, 2, 5, 1, 5);
        do_reset();
        step(CMD_ACT, "R3");   idle(20, "R3");
        step(CMD_RDA, "R7");   idle(20, "R7");
        for (int p = 0; p < 8; p++) begin
            rand_cfg();
            do_reset();
            rand_run(2500, p >= 6);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL all watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule